// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block takes a command frame for a pulse-generating driver controller over three slow wires: a serial clock, a serial data line and a latch strobe. Bits are captured on rising serial-clock edges and assembled into bytes. A rising latch edge commits the frame. At that moment the block reports a modulo-256 checksum status byte and decides whether the frame is good enough to act on. A frame that is short, long or has a non-zero sum is rejected. A rejected frame changes no setting and starts no pulse.

The first good frame after reset is a setup frame. Its byte 0 gives the turn-on wait and its byte 1 gives the extra turn-off wait, both counted in rising edges of a slow oscillator input. Every later good frame is a command frame. Its byte 0 carries an enable request in bit 0 and a pulse request in bit 1. Its byte 1 gives the pulse length in oscillator edges. The enable output follows the request only after a countdown. Turning on waits for the first stage. Turning off waits for the first stage plus the second stage.

All four inputs come from a slower domain and are brought into the system clock through a two-register synchronizer before any edge is detected.

Top module: `cmdfr_rx`

## Requirements
- R1: Bits are captured on the rising edge of `sclk` with the least significant bit of each byte first, and a frame is eight bytes (64 bits).
- R2: `csum_out` changes only on a latch rising edge, where it takes the modulo-256 sum of the complete bytes received since the previous latch (at most eight).
- R3: A 64-bit frame whose sum is non-zero drives `pulse_ok` low, starts no pulse and leaves the enable request unchanged; the next good frame can raise `pulse_ok` again.
- R4: A latch that follows a bit count other than 64 rejects the frame: `pulse_ok` goes low and no setting, enable request or pulse is changed.
- R5: The first good frame after reset loads the turn-on wait (byte 0) and the turn-off extra wait (byte 1), and leaves `pulse_ok`, `pulse_gate` and `en_out` low.
- R6: On the latch rising edge of a good command frame, `pulse_ok` takes bit 1 of byte 0; on the latch falling edge `pulse_ok` clears.
- R7: A good command frame with bit 1 of byte 0 set raises `pulse_gate` for byte 1 oscillator rising edges; a length of zero gives no pulse.
- R8: When bit 0 of byte 0 changes from 0 to 1, `en_out` rises after the turn-on wait in oscillator rising edges (at once if that wait is zero).
- R9: When bit 0 of byte 0 changes from 1 to 0, `en_out` falls after the sum of the turn-on wait and the turn-off extra wait in oscillator rising edges.
- R10: While `rst_n` is low at a clock edge all outputs are cleared and the next good frame is treated as a setup frame.
- R11: Each input passes two synchronizer registers; an input level first sampled at clock edge k takes effect on the outputs at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial bit clock, asynchronous |
| sdata | input | 1 | Serial data, asynchronous |
| latch | input | 1 | Frame commit strobe, asynchronous |
| osc | input | 1 | Slow oscillator that paces the waits and pulses |
| en_out | output | 1 | Delayed enable level |
| pulse_gate | output | 1 | High while a pulse is being produced |
| pulse_ok | output | 1 | Pulse-check flag, valid while latch is high |
| csum_out | output | BYTE_W | Checksum status of the last committed frame |

## Verification
On every cycle the checker enforces several timing rules. The checksum byte moves only after a latch rise. `pulse_ok` can rise only after a latch rise with a zero checksum, and it is low right after a latch fall. The enable and pulse outputs move only after an oscillator edge or a commit. Whether the wait lengths are counted correctly, whether bits are placed LSB first, and whether malformed frames leave the enable state untouched can only be shown by the bench's frame sequences against its cycle-level reference model.

// File: rtl/cmdfr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the serial command frame receiver.
// Assumes the line order below is used wherever the input vector is built.
package cmdfr_pkg;
    localparam int IX_SCLK   = 0;
    localparam int IX_SDATA  = 1;
    localparam int IX_LATCH  = 2;
    localparam int IX_OSC    = 3;
    localparam int N_LINES   = 4;

    localparam int CMD_EN_BIT    = 0;
    localparam int CMD_PULSE_BIT = 1;

    // Bytes of a frame that the block keeps: setting/command and length.
    localparam int HEAD_BYTES = 2;

    typedef enum logic {
        PH_SETUP = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;
endpackage

// File: rtl/cmdfr_sync.sv
`timescale 1ns/1ps
// Multi-line input synchronizer with edge detection.
// Each line passes STAGES registers; one more register holds the previous
// synchronized level so rising and falling edges come out as one-cycle strobes.
// Assumes STAGES >= 2.
module cmdfr_sync #(
    parameter int N_IN   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] raw,
    output logic [N_IN-1:0] lvl,
    output logic [N_IN-1:0] rise,
    output logic [N_IN-1:0] fall
);
    for (genvar g = 0; g < N_IN; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the raw line through the chain and remember the last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign lvl[g]  = chain[STAGES-1];
        assign rise[g] = chain[STAGES-1] & ~prev;
        assign fall[g] = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/cmdfr_deser.sv
`timescale 1ns/1ps
// Frame deserializer with running modulo-2^BW sum.
// Bits arrive LSB first; every BW bits form a byte added into the sum.
// Only the first HEAD bytes are kept. Bits past NBYTES*BW set an overrun flag.
// A clear strobe (the latch commit) restarts the frame and wins over a bit.
module cmdfr_deser #(
    parameter int NBYTES = 8,
    parameter int BW     = 8,
    parameter int HEAD   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_stb,
    input  logic                     bit_val,
    input  logic                     clear,
    output logic [HEAD-1:0][BW-1:0]  head,
    output logic [BW-1:0]            sum,
    output logic                     len_ok
);
    localparam int BIT_W = $clog2(BW);
    localparam int IDX_W = $clog2(NBYTES) + 1;

    logic [BW-1:0]    shreg;
    logic [BIT_W-1:0] bitpos;
    logic [IDX_W-1:0] byteidx;
    logic             over;
    logic [BW-1:0]    new_byte;

    assign new_byte = {bit_val, shreg[BW-1:1]};
    assign len_ok   = (byteidx == IDX_W'(NBYTES)) && (bitpos == '0) && !over;

    // Collect bits into bytes, accumulate the sum, keep the head bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg   <= '0;
            bitpos  <= '0;
            byteidx <= '0;
            over    <= 1'b0;
            sum     <= '0;
            head    <= '0;
        end else if (bit_stb) begin
            if (byteidx == IDX_W'(NBYTES)) begin
                over <= 1'b1;
            end else begin
                shreg <= new_byte;
                if (bitpos == BIT_W'(BW - 1)) begin
                    bitpos  <= '0;
                    byteidx <= byteidx + IDX_W'(1);
                    sum     <= sum + new_byte;
                    for (int k = 0; k < HEAD; k++) begin
                        if (byteidx == IDX_W'(k)) head[k] <= new_byte;
                    end
                end else begin
                    bitpos <= bitpos + BIT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cmdfr_timer.sv
`timescale 1ns/1ps
// Level countdown timer paced by a tick strobe.
// On load the output takes lvl_start (or lvl_end at once when len is zero)
// and after len ticks it takes the end level captured at load.
// A load always overrides a tick in the same cycle.
module cmdfr_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] len,
    input  logic          lvl_start,
    input  logic          lvl_end,
    output logic          lvl
);
    logic [CW-1:0] cnt;
    logic          run;
    logic          tgt;

    // Load a new wait or count down one tick toward the end level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
            tgt <= 1'b0;
            lvl <= 1'b0;
        end else if (load) begin
            cnt <= len;
            tgt <= lvl_end;
            run <= (len != '0);
            lvl <= (len == '0) ? lvl_end : lvl_start;
        end else if (run && tick) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
                lvl <= tgt;
                run <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmdfr_rx.sv
`timescale 1ns/1ps
// Serial command frame receiver, top level.
// Synchronizes the serial, latch and oscillator lines, deserializes frames,
// commits them on the latch rising edge, and drives a delayed enable level and
// a pulse gate through two countdown timers. The first good frame after reset
// programs the two wait lengths; later good frames are commands.
module cmdfr_rx #(
    parameter int FRAME_BYTES = 8,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              latch,
    input  logic              osc,
    output logic              en_out,
    output logic              pulse_gate,
    output logic              pulse_ok,
    output logic [BYTE_W-1:0] csum_out
);
    import cmdfr_pkg::*;

    localparam int EN_CW = BYTE_W + 1;

    logic [N_LINES-1:0] raw_lines, lvl, rise, fall;
    logic sclk_rise, sdata_lvl, latch_rise, latch_fall, osc_rise;

    logic [HEAD_BYTES-1:0][BYTE_W-1:0] head;
    logic [BYTE_W-1:0] frame_sum;
    logic              len_ok, frame_good;

    phase_e            phase;
    logic [BYTE_W-1:0] wait_on, wait_off;
    logic              en_cmd;

    logic              cmd_commit, new_en, en_load, pulse_load;
    logic [EN_CW-1:0]  en_len;
    logic              unused_lines;

    assign raw_lines[IX_SCLK]  = sclk;
    assign raw_lines[IX_SDATA] = sdata;
    assign raw_lines[IX_LATCH] = latch;
    assign raw_lines[IX_OSC]   = osc;

    cmdfr_sync #(.N_IN(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_lines),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign sclk_rise  = rise[IX_SCLK];
    assign sdata_lvl  = lvl[IX_SDATA];
    assign latch_rise = rise[IX_LATCH];
    assign latch_fall = fall[IX_LATCH];
    assign osc_rise   = rise[IX_OSC];
    assign unused_lines = ^{lvl[IX_SCLK], lvl[IX_LATCH], lvl[IX_OSC],
                            rise[IX_SDATA], fall[IX_SCLK], fall[IX_SDATA],
                            fall[IX_OSC]};

    cmdfr_deser #(.NBYTES(FRAME_BYTES), .BW(BYTE_W), .HEAD(HEAD_BYTES)) u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_stb(sclk_rise),
        .bit_val(sdata_lvl),
        .clear  (latch_rise),
        .head   (head),
        .sum    (frame_sum),
        .len_ok (len_ok)
    );

    assign frame_good = len_ok && (frame_sum == '0);
    assign cmd_commit = latch_rise && frame_good && (phase == PH_RUN);
    assign new_en     = head[0][CMD_EN_BIT];
    assign en_load    = cmd_commit && (new_en != en_cmd);
    assign pulse_load = cmd_commit && head[0][CMD_PULSE_BIT];
    assign en_len     = new_en ? EN_CW'(wait_on)
                               : (EN_CW'(wait_on) + EN_CW'(wait_off));

    // Commit the frame: checksum status, setup capture, command and check flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_SETUP;
            wait_on  <= '0;
            wait_off <= '0;
            en_cmd   <= 1'b0;
            pulse_ok <= 1'b0;
            csum_out <= '0;
        end else if (latch_rise) begin
            csum_out <= frame_sum;
            if (frame_good && phase == PH_SETUP) begin
                wait_on  <= head[0];
                wait_off <= head[1];
                phase    <= PH_RUN;
                pulse_ok <= 1'b0;
            end else if (frame_good) begin
                en_cmd   <= new_en;
                pulse_ok <= head[0][CMD_PULSE_BIT];
            end else begin
                pulse_ok <= 1'b0;
            end
        end else if (latch_fall) begin
            pulse_ok <= 1'b0;
        end
    end

    cmdfr_timer #(.CW(EN_CW)) u_en_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_rise),
        .load     (en_load),
        .len      (en_len),
        .lvl_start(en_out),
        .lvl_end  (new_en),
        .lvl      (en_out)
    );

    cmdfr_timer #(.CW(BYTE_W)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_rise),
        .load     (pulse_load),
        .len      (head[1]),
        .lvl_start(1'b1),
        .lvl_end  (1'b0),
        .lvl      (pulse_gate)
    );
endmodule

// File: rtl/cmdfr_chk.sv
`timescale 1ns/1ps
// Assertion checker for cmdfr_rx, attached by bind below.
// Observes the top ports and the synchronized latch and oscillator strobes.
module cmdfr_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_out,
    input logic              pulse_gate,
    input logic              pulse_ok,
    input logic [BYTE_W-1:0] csum_out,
    input logic              osc_tick,
    input logic              latch_rise,
    input logic              latch_fall
);
    // R2: the status byte moves only after a commit.
    a_r2_csum_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csum_out) |-> $past(latch_rise));

    // R3: the check flag never rises with a non-zero checksum.
    a_r3_ok_needs_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_ok) |-> (csum_out == '0));

    // R6: the check flag rises only at a commit.
    a_r6_ok_rises_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_ok) |-> $past(latch_rise));

    // R6: the check flag is low after a latch falling edge.
    a_r6_ok_clears_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        latch_fall |=> !pulse_ok);

    // R7: the pulse ends only on an oscillator edge or a reload.
    a_r7_gate_ends_paced: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_gate) |-> $past(osc_tick || latch_rise));

    // R8: the enable level moves only on an oscillator edge or a commit.
    a_r8_en_moves_paced: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_out) |-> $past(osc_tick || latch_rise));
endmodule

bind cmdfr_rx cmdfr_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_out    (en_out),
    .pulse_gate(pulse_gate),
    .pulse_ok  (pulse_ok),
    .csum_out  (csum_out),
    .osc_tick  (osc_rise),
    .latch_rise(latch_rise),
    .latch_fall(latch_fall)
);

// File: tb/sim_cmdfr_rx.sv
`timescale 1ns/1ps
// Bench for cmdfr_rx: directed frames plus a behavioural per-clock model.
module sim_cmdfr_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, latch = 1'b0, osc = 1'b0;
    logic en_out, pulse_gate, pulse_ok;
    logic [7:0] csum_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmdfr_rx u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .latch(latch),
        .osc(osc), .en_out(en_out), .pulse_gate(pulse_gate),
        .pulse_ok(pulse_ok), .csum_out(csum_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Oscillator: one rising edge every 8 clocks.
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            osc = ~osc;
        end
    end

    // ---------------- reference model (R11 latency, R1..R9 behaviour) -------
    int hq[4][$];
    int bits[$];
    int m_init, m_wa, m_wb, m_cmd, m_ok, m_csum;
    int e_out, e_cnt, e_run, e_tgt;
    int p_out, p_cnt, p_run;

    always @(posedge clk) begin
        int cur[4], prv[4], rawv[4];
        int nb, nfull, s, b0, b1, byt, newc, len, old_en;
        bit tick, sck_r, lat_r, lat_f;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) hq[i] = '{0, 0, 0};
            bits.delete();
            m_init = 0; m_wa = 0; m_wb = 0; m_cmd = 0; m_ok = 0; m_csum = 0;
            e_out = 0; e_cnt = 0; e_run = 0; e_tgt = 0;
            p_out = 0; p_cnt = 0; p_run = 0;
        end else begin
            rawv[0] = int'(sclk); rawv[1] = int'(sdata);
            rawv[2] = int'(latch); rawv[3] = int'(osc);
            for (int i = 0; i < 4; i++) begin
                hq[i].push_back(rawv[i]);
                if (hq[i].size() > 4) void'(hq[i].pop_front());
                cur[i] = hq[i][1];
                prv[i] = hq[i][0];
            end
            sck_r = (cur[0] == 1 && prv[0] == 0);
            lat_r = (cur[2] == 1 && prv[2] == 0);
            lat_f = (cur[2] == 0 && prv[2] == 1);
            tick  = (cur[3] == 1 && prv[3] == 0);
            old_en = e_out;
            if (tick && e_run != 0) begin
                e_cnt--;
                if (e_cnt == 0) begin e_out = e_tgt; e_run = 0; end
            end
            if (tick && p_run != 0) begin
                p_cnt--;
                if (p_cnt == 0) begin p_out = 0; p_run = 0; end
            end
            if (lat_r) begin
                nb = bits.size();
                nfull = ((nb > 64) ? 64 : nb) / 8;
                s = 0; b0 = 0; b1 = 0;
                for (int k = 0; k < nfull; k++) begin
                    byt = 0;
                    for (int j = 0; j < 8; j++) byt += bits[8*k+j] << j;
                    if (k == 0) b0 = byt;
                    if (k == 1) b1 = byt;
                    s += byt;
                end
                m_csum = s % 256;
                if (nb == 64 && m_csum == 0) begin
                    if (m_init == 0) begin
                        m_wa = b0; m_wb = b1; m_init = 1; m_ok = 0;
                    end else begin
                        newc = b0 % 2;
                        m_ok = (b0 / 2) % 2;
                        if (newc != m_cmd) begin
                            len = newc ? m_wa : m_wa + m_wb;
                            e_out = (len == 0) ? newc : old_en;
                            e_cnt = len; e_run = (len != 0); e_tgt = newc;
                            m_cmd = newc;
                        end
                        if (m_ok != 0) begin
                            p_out = (b1 != 0); p_cnt = b1; p_run = (b1 != 0);
                        end
                    end
                end else begin
                    m_ok = 0;
                end
                bits.delete();
            end else begin
                if (lat_f) m_ok = 0;
                if (sck_r) bits.push_back(cur[1]);
            end
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R11 model en_out", int'(en_out), e_out);
            chk("R11 model pulse_gate", int'(pulse_gate), p_out);
            chk("R11 model pulse_ok", int'(pulse_ok), m_ok);
            chk("R11 model csum_out", int'(csum_out), m_csum);
        end
    end

    // ---------------- stimulus helpers --------------------------------------
    function automatic logic [71:0] mk(input logic [7:0] a, input logic [7:0] b);
        logic [71:0] d = '0;
        d[7:0]   = a;
        d[15:8]  = b;
        d[63:56] = 8'(0 - (a + b));
        return d;
    endfunction

    task automatic send(input logic [71:0] d, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); sdata = d[i]; sclk = 1'b0;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (2) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe(input int exp_ok, input string tag);
        @(negedge clk); latch = 1'b1;
        repeat (4) @(negedge clk);
        chk(tag, int'(pulse_ok), exp_ok);
        repeat (2) @(negedge clk);
        latch = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 pulse_ok after latch fall", int'(pulse_ok), 0);
    endtask

    // ---------------- directed sequence -------------------------------------
    initial begin
        logic [71:0] d;
        repeat (5) @(negedge clk);
        chk("R10 reset en_out", int'(en_out), 0);
        chk("R10 reset pulse_gate", int'(pulse_gate), 0);
        chk("R10 reset pulse_ok", int'(pulse_ok), 0);
        chk("R10 reset csum_out", int'(csum_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Setup frame: turn-on wait 3, turn-off extra wait 2.
        send(mk(8'd3, 8'd2), 64);
        strobe(0, "R5 setup frame pulse_ok");
        chk("R2 setup frame csum", int'(csum_out), 0);
        repeat (60) @(negedge clk);
        chk("R5 setup frame leaves en_out low", int'(en_out), 0);

        // Enable on with pulse of 4 ticks.
        send(mk(8'h03, 8'd4), 64);
        strobe(1, "R6 command pulse_ok high");
        chk("R8 en_out still waiting", int'(en_out), 0);
        chk("R7 pulse_gate running", int'(pulse_gate), 1);
        repeat (40) @(negedge clk);
        chk("R8 en_out after turn-on wait", int'(en_out), 1);
        chk("R7 pulse_gate ended", int'(pulse_gate), 0);

        // Bad checksum: disable request with a stray byte 7 of 5.
        d = '0; d[63:56] = 8'd5;
        send(d, 64);
        strobe(0, "R3 bad sum pulse_ok");
        chk("R3 bad sum csum", int'(csum_out), 5);
        chk("R3 bad sum no pulse", int'(pulse_gate), 0);
        repeat (80) @(negedge clk);
        chk("R3 bad sum keeps en_out", int'(en_out), 1);

        // Short frame of 40 bits.
        send(mk(8'h02, 8'd2), 40);
        strobe(0, "R4 short frame pulse_ok");
        chk("R4 short frame csum", int'(csum_out), 4);
        repeat (80) @(negedge clk);
        chk("R4 short frame keeps en_out", int'(en_out), 1);

        // Good disable frame with a pulse restores the flag.
        send(mk(8'h02, 8'd2), 64);
        strobe(1, "R3 good frame restores pulse_ok");
        repeat (10) @(negedge clk);
        chk("R9 en_out held during turn-off wait", int'(en_out), 1);
        repeat (60) @(negedge clk);
        chk("R9 en_out after turn-off wait", int'(en_out), 0);

        // Long frame of 72 bits asking for enable.
        send(mk(8'h01, 8'd0), 72);
        strobe(0, "R4 long frame pulse_ok");
        repeat (80) @(negedge clk);
        chk("R4 long frame keeps en_out", int'(en_out), 0);

        // Bit order: first bit sent is byte 0 bit 0.
        d = '0; d[0] = 1'b1;
        send(d, 64);
        strobe(0, "R1 order frame pulse_ok");
        chk("R1 LSB-first csum", int'(csum_out), 1);
        repeat (20) @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R11 act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule